// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the transfer engine behind an I2C master. Software places 9-bit command words into a transmit queue. A word is either a byte to send or a request to read one byte. The sequencer turns the queue into bus operations: START, the 7-bit target address with its direction bit, byte writes, byte reads, repeated START and STOP. These go out on an abstract request/done operation interface, and a separate bit-level engine carries each one out on the wires. Each byte read back lands in a receive queue, which software drains one entry at a time.

A transfer begins when the block is enabled and the transmit queue holds a word. When the direction of the next command differs from the current one, the sequencer either issues a repeated START or closes with STOP and opens a new transfer, depending on a restart-enable input. A stop-hold input keeps the bus claimed while the queue is empty, so that a later message can follow with a repeated START. A missing acknowledge ends the transfer, flushes the transmit queue and records why the transfer aborted. Disabling the block takes effect only once the sequencer is idle.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `status` is 6'b000110, and `enable_status`, `rx_byte`, `abort_src` and `bus_req` are all zero.
- R2: A command word with bit 8 set is a read request, and its bits 7:0 are ignored. With bit 8 clear, bits 7:0 are sent as a WRITE operation (op 4). A transfer opens with START (op 1), followed by a WRITE of the address byte {target[6:0], dir}, where dir is 1 for a read.
- R3: When the transmit queue is empty and `stop_hold` is 0, the sequencer issues STOP (op 3) and returns to idle. While `stop_hold` is 1, an empty queue leaves the bus held: `status[5]` stays 1 and no operation is requested.
- R4: When the next command's direction differs from the current one and `restart_en` is 1, the sequencer issues RSTART (op 2) followed by the new address byte. When `restart_en` is 0, it issues STOP, then START and the new address byte.
- R5: A READ (op 5) carries `bus_mnack`=1 when the read will be followed by STOP (queue empty and `stop_hold` 0) or by a write command. Otherwise `bus_mnack` is 0.
- R6: Received bytes are returned in arrival order. A one-cycle `rx_pop` loads `rx_byte` on the next cycle. A pop while the receive queue is empty loads 0 and pulses `rx_underflow` for one cycle.
- R7: Each queue holds FIFO_DEPTH (16) entries. A push into a full queue is dropped and pulses `tx_overflow` or `rx_overflow` for one cycle.
- R8: The `status` bits are: bit5 master active, bit4 receive full, bit3 receive not empty, bit2 transmit empty, bit1 transmit not full, bit0 activity (master active or transmit not empty).
- R9: A missing acknowledge on the address byte sets `abort_src[0]`, flushes the transmit queue and issues STOP.
- R10: A missing acknowledge on a data byte sets `abort_src[3]`, flushes the transmit queue and issues STOP. `abort_clr` zeroes `abort_src`.
- R11: A target-address write takes effect only while the transmit queue is empty and the master is idle. At any other time it is ignored.
- R12: While `enable` is 0, no new transfer starts. Deasserting `enable` during a held transfer issues STOP. `enable_status` falls only one cycle after the sequencer is idle.
- R13: `bus_req` and `bus_op` stay stable until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable request |
| enable_status | output | 1 | Enable in effect; falls once idle |
| restart_en | input | 1 | Permit repeated START on direction change |
| stop_hold | input | 1 | Hold the bus instead of STOP when queue empties |
| tar_wr | input | 1 | Target address write strobe |
| tar_wdata | input | 7 | New target address |
| cmd_push | input | 1 | Push a command word |
| cmd_word | input | 9 | Command word (bit 8 = read) |
| tx_overflow | output | 1 | Pulse: command push dropped |
| rx_pop | input | 1 | Pop the receive queue |
| rx_byte | output | 8 | Byte returned by the last pop |
| rx_overflow | output | 1 | Pulse: received byte dropped |
| rx_underflow | output | 1 | Pulse: pop of empty receive queue |
| status | output | 6 | Status flags (see R8) |
| abort_clr | input | 1 | Clear abort source bits |
| abort_src | output | 4 | Abort cause: bit0 address, bit3 data |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 3 | 1 START, 2 RSTART, 3 STOP, 4 WRITE, 5 READ |
| bus_wdata | output | 8 | Byte for WRITE |
| bus_mnack | output | 1 | Master not-acknowledge for READ |
| bus_done | input | 1 | Bus operation complete |
| bus_ack | input | 1 | Slave acknowledged the WRITE |
| bus_rdata | input | 8 | Byte returned by READ |

## Verification
A wrong sequencer state shows up on the very next bus request. A misplaced repeated START, an extra STOP, a wrong address direction bit or a wrong acknowledge flag on a read becomes the first mismatching operation in the operation stream. Queue pointer or count errors appear as a wrong `status` word at once, or as misordered bytes on the first pop that follows. A broken target-address guard or a broken abort path shows on the next transfer's address byte, or as leftover commands being issued after the STOP.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  localparam int TAR_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = BYTE_W + 1;
  localparam int OP_W    = 3;
  localparam int STAT_W  = 6;
  localparam int ABRT_W  = 4;
  localparam int ABRT_ADDR_BIT = 0;
  localparam int ABRT_DATA_BIT = 3;

  typedef enum logic [OP_W-1:0] {
    BOP_NONE   = 3'd0,
    BOP_START  = 3'd1,
    BOP_RSTART = 3'd2,
    BOP_STOP   = 3'd3,
    BOP_WRITE  = 3'd4,
    BOP_READ   = 3'd5
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_HOLD,
    ST_DATA,
    ST_RSTART,
    ST_STOP
  } seq_state_e;

  // Command word decode: top bit marks a read request.
  function automatic logic is_read(input logic [CMD_W-1:0] w);
    return w[CMD_W-1];
  endfunction

  // Address phase byte: 7-bit target followed by the direction bit.
  function automatic logic [BYTE_W-1:0] addr_byte(input logic [TAR_W-1:0] tar,
                                                  input logic rd);
    return {tar, rd};
  endfunction

  // A read is not-acknowledged when it is the last before STOP or a write.
  function automatic logic read_nack(input logic q_empty, input logic hold,
                                     input logic next_is_read);
    return q_empty ? !hold : !next_is_read;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic mact,
                                                    input logic rx_full,
                                                    input logic rx_nempty,
                                                    input logic tx_empty,
                                                    input logic tx_nfull);
    return {mact, rx_full, rx_nempty, tx_empty, tx_nfull, mact | !tx_empty};
  endfunction

endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || do_pop);
  assign head    = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      wr_q      <= '0;
      cnt_q     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= push && !flush && !do_push;
      underflow <= pop && empty;
      if (flush) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (do_push) wr_q <= bump(wr_q);
        if (do_pop)  rd_q <= bump(rd_q);
        cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(full));

  // R6
  unf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(empty));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> (int'(cnt_q) <= int'($past(cnt_q)) + 1 &&
                       int'(cnt_q) + 1 >= int'($past(cnt_q))));

endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              restart_en,
  input  logic              stop_hold,
  input  logic [TAR_W-1:0]  tar,
  input  logic [CMD_W-1:0]  tx_head,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              tx_flush,
  output logic              rx_push,
  output logic              bus_req,
  output logic [OP_W-1:0]   bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_mnack,
  input  logic              bus_done,
  input  logic              bus_ack,
  output logic              master_active,
  output logic              enable_status,
  output logic              addr_nack_evt,
  output logic              data_nack_evt
);

  seq_state_e       state_q, state_d;
  logic             dir_q, dir_d;
  logic [CMD_W-1:0] cur_q, cur_d;
  logic             en_st_q;

  always_comb begin
    state_d       = state_q;
    dir_d         = dir_q;
    cur_d         = cur_q;
    tx_pop        = 1'b0;
    rx_push       = 1'b0;
    addr_nack_evt = 1'b0;
    data_nack_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (enable && !tx_empty) begin
          dir_d   = is_read(tx_head);
          state_d = ST_START;
        end
      end
      ST_START, ST_RSTART: begin
        if (bus_done) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (bus_done) begin
          if (!bus_ack) begin
            addr_nack_evt = 1'b1;
            state_d       = ST_STOP;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!enable) begin
          state_d = ST_STOP;
        end else if (!tx_empty) begin
          if (is_read(tx_head) != dir_q) begin
            if (restart_en) begin
              dir_d   = is_read(tx_head);
              state_d = ST_RSTART;
            end else begin
              state_d = ST_STOP;
            end
          end else begin
            tx_pop  = 1'b1;
            cur_d   = tx_head;
            state_d = ST_DATA;
          end
        end else if (!stop_hold) begin
          state_d = ST_STOP;
        end
      end
      ST_DATA: begin
        if (bus_done) begin
          if (is_read(cur_q)) begin
            rx_push = 1'b1;
            state_d = ST_HOLD;
          end else if (!bus_ack) begin
            data_nack_evt = 1'b1;
            state_d       = ST_STOP;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_STOP: begin
        if (bus_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tx_flush = addr_nack_evt | data_nack_evt;

  always_comb begin
    bus_op    = BOP_NONE;
    bus_wdata = '0;
    bus_mnack = 1'b0;
    unique case (state_q)
      ST_START:  bus_op = BOP_START;
      ST_RSTART: bus_op = BOP_RSTART;
      ST_STOP:   bus_op = BOP_STOP;
      ST_ADDR: begin
        bus_op    = BOP_WRITE;
        bus_wdata = addr_byte(tar, dir_q);
      end
      ST_DATA: begin
        if (is_read(cur_q)) begin
          bus_op    = BOP_READ;
          bus_mnack = read_nack(tx_empty, stop_hold, is_read(tx_head));
        end else begin
          bus_op    = BOP_WRITE;
          bus_wdata = cur_q[BYTE_W-1:0];
        end
      end
      default: bus_op = BOP_NONE;
    endcase
  end

  assign bus_req       = (bus_op != BOP_NONE);
  assign master_active = (state_q != ST_IDLE);
  assign enable_status = en_st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      cur_q   <= '0;
      en_st_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      cur_q   <= cur_d;
      en_st_q <= enable | (en_st_q & master_active);
    end
  end

  // R13
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_op)));

  // R12
  off_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_st_q |-> !master_active);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic              enable_status,
  input  logic              restart_en,
  input  logic              stop_hold,
  input  logic              tar_wr,
  input  logic [6:0]        tar_wdata,
  input  logic              cmd_push,
  input  logic [8:0]        cmd_word,
  output logic              tx_overflow,
  input  logic              rx_pop,
  output logic [7:0]        rx_byte,
  output logic              rx_overflow,
  output logic              rx_underflow,
  output logic [5:0]        status,
  input  logic              abort_clr,
  output logic [3:0]        abort_src,
  output logic              bus_req,
  output logic [2:0]        bus_op,
  output logic [7:0]        bus_wdata,
  output logic              bus_mnack,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);

  logic [CMD_W-1:0]  tx_head;
  logic              tx_empty, tx_full, tx_pop, tx_flush, tx_underflow;
  logic [BYTE_W-1:0] rx_head;
  logic              rx_empty, rx_full, rx_push;
  logic              master_active, addr_nack_evt, data_nack_evt;
  logic [TAR_W-1:0]  tar_q;
  logic [BYTE_W-1:0] rx_byte_q;
  logic [ABRT_W-1:0] abrt_q;

  i2cseq_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_push), .push_data(cmd_word),
    .pop(tx_pop), .flush(tx_flush),
    .head(tx_head), .empty(tx_empty), .full(tx_full),
    .overflow(tx_overflow), .underflow(tx_underflow)
  );

  i2cseq_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(bus_rdata),
    .pop(rx_pop), .flush(1'b0),
    .head(rx_head), .empty(rx_empty), .full(rx_full),
    .overflow(rx_overflow), .underflow(rx_underflow)
  );

  i2cseq_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .restart_en(restart_en), .stop_hold(stop_hold),
    .tar(tar_q),
    .tx_head(tx_head), .tx_empty(tx_empty),
    .tx_pop(tx_pop), .tx_flush(tx_flush),
    .rx_push(rx_push),
    .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
    .bus_mnack(bus_mnack), .bus_done(bus_done), .bus_ack(bus_ack),
    .master_active(master_active), .enable_status(enable_status),
    .addr_nack_evt(addr_nack_evt), .data_nack_evt(data_nack_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tar_q     <= '0;
      rx_byte_q <= '0;
      abrt_q    <= '0;
    end else begin
      if (tar_wr && tx_empty && !master_active) tar_q <= tar_wdata;
      if (rx_pop) rx_byte_q <= rx_empty ? '0 : rx_head;
      abrt_q <= (abort_clr ? '0 : abrt_q)
              | (ABRT_W'(addr_nack_evt) << ABRT_ADDR_BIT)
              | (ABRT_W'(data_nack_evt) << ABRT_DATA_BIT);
    end
  end

  assign rx_byte   = rx_byte_q;
  assign abort_src = abrt_q;
  assign status    = pack_status(master_active, rx_full, !rx_empty, tx_empty, !tx_full);

  // R11
  tar_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tar_q) |-> $past(tx_empty && !master_active));

  // R9
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_nack_evt || data_nack_evt) |=> tx_empty);

  // R2
  tx_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_underflow);

endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, restart_en = 1'b1, stop_hold = 1'b0;
  logic tar_wr = 1'b0;
  logic [6:0] tar_wdata = '0;
  logic cmd_push = 1'b0;
  logic [8:0] cmd_word = '0;
  logic rx_pop = 1'b0, abort_clr = 1'b0;
  logic bus_done = 1'b0, bus_ack = 1'b1;
  logic [7:0] bus_rdata = '0;
  logic enable_status, tx_overflow, rx_overflow, rx_underflow;
  logic [7:0] rx_byte, bus_wdata;
  logic [5:0] status;
  logic [3:0] abort_src;
  logic bus_req, bus_mnack;
  logic [2:0] bus_op;

  i2c_cmd_seq uut (.*);

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0, rx_ovf_cnt = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  rx_exp_q[$];
  string cur_req = "R1";
  logic nack_en = 1'b0;
  logic [7:0] nack_byte = '0;
  logic [7:0] rd_val = 8'hA0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ev(input logic [2:0] op, input logic mn, input logic [7:0] d);
    return {op, mn, d};
  endfunction

  task automatic expect_op(input logic [2:0] op, input logic mn, input logic [7:0] d);
    exp_q.push_back(ev(op, mn, d));
  endtask

  // bus model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      if (bus_req) begin
        logic [11:0] act;
        @(negedge clk);
        act = ev(bus_op, (bus_op == 3'd5) ? bus_mnack : 1'b0,
                 (bus_op == 3'd4) ? bus_wdata : 8'h00);
        if (exp_q.size() == 0) chk({cur_req, " unexpected op"}, 32'(act), 32'hFFFF_FFFF);
        else chk(cur_req, 32'(act), 32'(exp_q.pop_front()));
        bus_ack = !(nack_en && bus_op == 3'd4 && bus_wdata == nack_byte);
        bus_rdata = rd_val;
        if (bus_op == 3'd5) begin
          rx_exp_q.push_back(rd_val);
          rd_val = rd_val + 8'd1;
        end
        bus_done = 1'b1;
      end
    end
  end

  always @(negedge clk) if (rx_overflow) rx_ovf_cnt++;

  task automatic push(input logic [8:0] w);
    cmd_push = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    bit ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !status[5]) begin ok = 1'b1; break; end
    end
    chk({req, " all ops seen, idle"}, 32'(ok), 32'd1);
  endtask

  task automatic wait_ops;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_check(input string req);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    chk(req, 32'(rx_byte), 32'(rx_exp_q.pop_front()));
  endtask

  task automatic pop_empty(input string req);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    chk({req, " byte"}, 32'(rx_byte), 32'd0);
    chk({req, " flag"}, 32'(rx_underflow), 32'd1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(status), 32'h06);
    chk("R1 enable_status", 32'(enable_status), 32'd0);
    chk("R1 rx_byte", 32'(rx_byte), 32'd0);
    chk("R1 abort_src", 32'(abort_src), 32'd0);
    chk("R1 bus_req", 32'(bus_req), 32'd0);

    tar_wr = 1'b1; tar_wdata = 7'h2A;
    @(negedge clk);
    tar_wr = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // R2 R3: two writes then STOP
    cur_req = "R2";
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h11);
    expect_op(4, 0, 8'h22); expect_op(3, 0, 0);
    push(9'h011); push(9'h022);
    wait_idle("R3");

    // R5 R6: three reads, low byte of a read ignored
    cur_req = "R5";
    expect_op(1, 0, 0); expect_op(4, 0, 8'h55);
    expect_op(5, 0, 0); expect_op(5, 0, 0); expect_op(5, 1, 0); expect_op(3, 0, 0);
    push(9'h100); push(9'h1FF); push(9'h100);
    wait_idle("R5");
    chk("R8 rx not empty", 32'(status), 32'h0E);
    pop_check("R6 first"); pop_check("R6 second"); pop_check("R6 third");
    pop_empty("R6 underflow");

    // R4 restart disabled: STOP then START
    cur_req = "R4";
    restart_en = 1'b0;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h44); expect_op(3, 0, 0);
    expect_op(1, 0, 0); expect_op(4, 0, 8'h55); expect_op(5, 1, 0); expect_op(3, 0, 0);
    push(9'h044); push(9'h100);
    wait_idle("R4");
    pop_check("R4 byte");

    // R4 R5 restart enabled, read followed by write gets NACK
    restart_en = 1'b1;
    cur_req = "R5";
    expect_op(1, 0, 0); expect_op(4, 0, 8'h55); expect_op(5, 1, 0);
    expect_op(2, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h66); expect_op(3, 0, 0);
    push(9'h100); push(9'h066);
    wait_idle("R4");
    pop_check("R6 byte");

    // R9 address no-ack
    cur_req = "R9";
    nack_en = 1'b1; nack_byte = 8'h54;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(3, 0, 0);
    push(9'h077); push(9'h088);
    wait_idle("R9");
    chk("R9 abort_src", 32'(abort_src), 32'h1);
    chk("R9 tx flushed", 32'(status), 32'h06);
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;
    chk("R10 clear", 32'(abort_src), 32'h0);

    // R10 data no-ack
    cur_req = "R10";
    nack_byte = 8'h99;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h99); expect_op(3, 0, 0);
    push(9'h099); push(9'h0AA); push(9'h0BB);
    wait_idle("R10");
    chk("R10 abort_src", 32'(abort_src), 32'h8);
    chk("R10 tx flushed", 32'(status), 32'h06);
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;
    nack_en = 1'b0;

    // R3 stop hold, then repeated START
    cur_req = "R3";
    stop_hold = 1'b1;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h33);
    push(9'h033);
    wait_ops();
    repeat (10) @(negedge clk);
    chk("R3 held active", 32'(status[5]), 32'd1);
    chk("R3 no request", 32'(bus_req), 32'd0);
    cur_req = "R4";
    expect_op(2, 0, 0); expect_op(4, 0, 8'h55); expect_op(5, 0, 0);
    push(9'h100);
    wait_ops();
    cur_req = "R3";
    expect_op(3, 0, 0);
    stop_hold = 1'b0;
    wait_idle("R3");
    pop_check("R6 held read");

    // R11 address change ignored while busy
    cur_req = "R11";
    stop_hold = 1'b1;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h54); expect_op(4, 0, 8'h12);
    push(9'h012);
    wait_ops();
    tar_wr = 1'b1; tar_wdata = 7'h10; @(negedge clk); tar_wr = 1'b0;
    expect_op(2, 0, 0); expect_op(4, 0, 8'h55); expect_op(5, 0, 0);
    push(9'h100);
    wait_ops();
    expect_op(3, 0, 0);
    stop_hold = 1'b0;
    wait_idle("R11");
    pop_check("R11 byte");
    tar_wr = 1'b1; tar_wdata = 7'h10; @(negedge clk); tar_wr = 1'b0;

    // R7 R12 transmit overflow while disabled
    cur_req = "R7";
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 disabled", 32'(enable_status), 32'd0);
    for (int i = 0; i < 16; i++) push(9'(9'h040 + i));
    push(9'h0EE);
    chk("R7 tx overflow", 32'(tx_overflow), 32'd1);
    chk("R8 tx full", 32'(status), 32'h01);
    chk("R12 no start", 32'(bus_req), 32'd0);
    expect_op(1, 0, 0); expect_op(4, 0, 8'h20);
    for (int i = 0; i < 16; i++) expect_op(4, 0, 8'(8'h40 + i));
    expect_op(3, 0, 0);
    enable = 1'b1;
    wait_idle("R7");

    // R7 receive overflow
    cur_req = "R7";
    enable = 1'b0; stop_hold = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) push(9'h100);
    expect_op(1, 0, 0); expect_op(4, 0, 8'h21);
    for (int i = 0; i < 17; i++) expect_op(5, 0, 0);
    enable = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (status[3]) break;
    end
    push(9'h1AB);
    wait_ops();
    expect_op(3, 0, 0);
    stop_hold = 1'b0;
    wait_idle("R7");
    chk("R7 rx overflow", 32'(rx_ovf_cnt), 32'd1);
    chk("R8 rx full", 32'(status), 32'h1E);
    void'(rx_exp_q.pop_back());
    for (int i = 0; i < 16; i++) pop_check("R7 kept byte");
    pop_empty("R6 underflow after drain");

    // R12 disable during held transfer
    cur_req = "R12";
    stop_hold = 1'b1;
    expect_op(1, 0, 0); expect_op(4, 0, 8'h20); expect_op(4, 0, 8'h5A);
    push(9'h05A);
    wait_ops();
    expect_op(3, 0, 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R12 status still on", 32'(enable_status), 32'd1);
    wait_idle("R12");
    @(negedge clk);
    chk("R12 status off", 32'(enable_status), 32'd0);
    stop_hold = 1'b0;

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule